// File: doc/BRIEF.md
# Opmask ALU with branch flags

This block performs arithmetic, bitwise and shift operations on vector predicate masks at a selectable width of 8 or 16 bits. A caller presents two mask operands, a 4-bit opcode, a width select and a shift count, and raises `op_valid` for one cycle. On the next clock edge the block registers a 64-bit result. Every result is zero-extended from the active width, and operand bits above the active width never affect any output.

Two test operations do not write the result. Instead they produce a zero flag and a carry flag that a branch unit can consume. One test derives both flags from an AND and an AND-NOT of the operands. The other derives them from the OR of the operands: it reports an all-clear result and an all-set result.

A small two-state sequencer, with states `ST_QUIET` and `ST_FRESH`, drives `flag_valid`. Transition `GO_FRESH` is taken on any accepted test operation. Transition `GO_QUIET` is taken on any cycle without one. `flag_valid` is high for exactly the cycle after each accepted test operation.

Top module: `kmask_alu`

## Requirements
- R1: After reset, `result`, `zf`, `cf` and `flag_valid` are all zero.
- R2: Opcode 0 (ADD) returns `(src_a + src_b)` modulo 2^W, where W is 8 when `wide`=0 and 16 when `wide`=1. Result bits at and above W are zero.
- R3: The bitwise opcodes each return a W-bit result, zero-extended:
  - 1: AND returns `a & b`.
  - 2: ANDN returns `(~a) & b`.
  - 3: OR returns `a | b`.
  - 4: XOR returns `a ^ b`.
  - 5: XNOR returns `~(a ^ b)`.
  - 6: NOT returns `~a`.
- R4: Opcode 7 (SHL) and opcode 8 (SHR) shift the W-bit `src_a` logically by `shamt`. A `shamt` greater than or equal to W yields zero.
- R5: Opcode 9 (MOV) returns the low W bits of `src_a`, zero-extended to 64 bits.
- R6: Opcode 10 (TEST) sets `zf` when `(a & b)` over W bits is zero, and sets `cf` when `((~a) & b)` over W bits is zero.
- R7: Opcode 11 (ORTEST) sets `zf` when `(a | b)` over W bits is zero, and sets `cf` when `(a | b)` over W bits is all ones.
- R8: Only opcodes 10 and 11 change `zf` and `cf`. `flag_valid` is 1 in the cycle after an accepted test operation and 0 in every other cycle.
- R9: The result register keeps its value in each of these cases:
  - a cycle without `op_valid`;
  - a test operation;
  - a reserved opcode (12 to 15), which also leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation on this edge |
| opcode | input | 4 | Operation code (see R2 to R9) |
| wide | input | 1 | 0: 8-bit masks, 1: 16-bit masks |
| src_a | input | 16 | First mask operand |
| src_b | input | 16 | Second mask operand |
| shamt | input | 5 | Constant shift count |
| result | output | 64 | Registered, zero-extended result |
| zf | output | 1 | Registered zero flag |
| cf | output | 1 | Registered carry flag |
| flag_valid | output | 1 | High the cycle after a test operation |

## Verification
Narrow operations are applied with junk in operand bits 15:8. This shows whether masking happens before or after the operation, and whether an add carry leaks into bit 8. Shift counts just below, exactly at and well above the active width separate a correct range guard from a plain shifter. Test operands are chosen to give each of the four zero/carry combinations, including an empty second operand that sets both flags. Interleaving non-test operations, reserved opcodes, idle cycles and back-to-back tests shows whether the flags and `flag_valid` move only when a test operation is accepted.

// File: rtl/kmask_pkg.sv
package kmask_pkg;

    typedef enum logic [3:0] {
        KOP_ADD    = 4'd0,
        KOP_AND    = 4'd1,
        KOP_ANDN   = 4'd2,
        KOP_OR     = 4'd3,
        KOP_XOR    = 4'd4,
        KOP_XNOR   = 4'd5,
        KOP_NOT    = 4'd6,
        KOP_SHL    = 4'd7,
        KOP_SHR    = 4'd8,
        KOP_MOV    = 4'd9,
        KOP_TEST   = 4'd10,
        KOP_ORTEST = 4'd11
    } kop_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_FRESH = 1'b1
    } fstate_e;

    function automatic logic kop_is_test(input logic [3:0] code);
        return (code == KOP_TEST) || (code == KOP_ORTEST);
    endfunction

    function automatic logic kop_writes_result(input logic [3:0] code);
        return code <= KOP_MOV;
    endfunction

endpackage

// File: rtl/kmask_bitop.sv
module kmask_bitop
    import kmask_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic [3:0]    op,
    input  logic [MW-1:0] a,
    input  logic [MW-1:0] b,
    input  logic [MW-1:0] act_mask,
    output logic [MW-1:0] y
);

    logic [MW-1:0] raw;

    always_comb begin
        case (op)
            KOP_ADD:  raw = a + b;
            KOP_AND:  raw = a & b;
            KOP_ANDN: raw = (~a) & b;
            KOP_OR:   raw = a | b;
            KOP_XOR:  raw = a ^ b;
            KOP_XNOR: raw = ~(a ^ b);
            KOP_NOT:  raw = ~a;
            KOP_MOV:  raw = a;
            default:  raw = '0;
        endcase
        y = raw & act_mask;
    end

endmodule

// File: rtl/kmask_shift.sv
module kmask_shift #(
    parameter int MW   = 16,
    parameter int SH_W = 5
) (
    input  logic [MW-1:0]   a,
    input  logic [SH_W-1:0] shamt,
    input  logic [SH_W:0]   act_width,
    input  logic            to_right,
    input  logic [MW-1:0]   act_mask,
    output logic [MW-1:0]   y
);

    logic          out_of_range;
    logic [MW-1:0] a_m;
    logic [MW-1:0] shifted;

    assign a_m          = a & act_mask;
    assign out_of_range = {1'b0, shamt} >= act_width;
    assign shifted      = to_right ? (a_m >> shamt) : (a_m << shamt);
    assign y            = out_of_range ? '0 : (shifted & act_mask);

endmodule

// File: rtl/kmask_flags.sv
module kmask_flags #(
    parameter int MW = 16
) (
    input  logic [MW-1:0] a,
    input  logic [MW-1:0] b,
    input  logic [MW-1:0] act_mask,
    input  logic          or_mode,
    output logic          zf_n,
    output logic          cf_n
);

    logic [MW-1:0] t_and;
    logic [MW-1:0] t_andn;
    logic [MW-1:0] t_or;

    assign t_and  = a & b & act_mask;
    assign t_andn = (~a) & b & act_mask;
    assign t_or   = (a | b) & act_mask;

    always_comb begin
        if (or_mode) begin
            zf_n = (t_or == '0);
            cf_n = (t_or == act_mask);
        end else begin
            zf_n = (t_and == '0);
            cf_n = (t_andn == '0);
        end
    end

endmodule

// File: rtl/kmask_alu.sv
module kmask_alu
    import kmask_pkg::*;
#(
    parameter int MW    = 16,
    parameter int NW    = 8,
    parameter int RES_W = 64,
    parameter int SH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       opcode,
    input  logic             wide,
    input  logic [MW-1:0]    src_a,
    input  logic [MW-1:0]    src_b,
    input  logic [SH_W-1:0]  shamt,
    output logic [RES_W-1:0] result,
    output logic             zf,
    output logic             cf,
    output logic             flag_valid
);

    localparam int PAD_W = RES_W - MW;

    logic [MW-1:0] act_mask;
    logic [SH_W:0] act_width;
    logic [MW-1:0] bit_y;
    logic [MW-1:0] sh_y;
    logic [MW-1:0] nxt_res;
    logic          zf_n;
    logic          cf_n;
    logic          is_shift;
    logic          res_we;
    logic          flag_we;
    logic [MW-1:0] res_q;
    fstate_e       state;
    fstate_e       state_nxt;

    for (genvar i = 0; i < MW; i++) begin : g_mask
        assign act_mask[i] = wide | (i < NW);
    end

    assign act_width = wide ? (SH_W+1)'(MW) : (SH_W+1)'(NW);

    kmask_bitop #(.MW(MW)) i_bitop (
        .op       (opcode),
        .a        (src_a),
        .b        (src_b),
        .act_mask (act_mask),
        .y        (bit_y)
    );

    kmask_shift #(.MW(MW), .SH_W(SH_W)) i_shift (
        .a         (src_a),
        .shamt     (shamt),
        .act_width (act_width),
        .to_right  (opcode == KOP_SHR),
        .act_mask  (act_mask),
        .y         (sh_y)
    );

    kmask_flags #(.MW(MW)) i_flags (
        .a        (src_a),
        .b        (src_b),
        .act_mask (act_mask),
        .or_mode  (opcode == KOP_ORTEST),
        .zf_n     (zf_n),
        .cf_n     (cf_n)
    );

    assign is_shift = (opcode == KOP_SHL) || (opcode == KOP_SHR);
    assign nxt_res  = is_shift ? sh_y : bit_y;
    assign res_we   = op_valid && kop_writes_result(opcode);
    assign flag_we  = op_valid && kop_is_test(opcode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            zf    <= 1'b0;
            cf    <= 1'b0;
        end else begin
            if (res_we) begin
                res_q <= nxt_res;
            end
            if (flag_we) begin
                zf <= zf_n;
                cf <= cf_n;
            end
        end
    end

    assign result = {{PAD_W{1'b0}}, res_q};

    // Flag-valid sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_QUIET;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions GO_FRESH / GO_QUIET
    always_comb begin
        unique case (state)
            ST_QUIET: state_nxt = flag_we ? ST_FRESH : ST_QUIET;
            ST_FRESH: state_nxt = flag_we ? ST_FRESH : ST_QUIET;
            default:  state_nxt = ST_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_FRESH: flag_valid = 1'b1;
            default:  flag_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/kmask_alu_chk.sv
module kmask_alu_chk #(
    parameter int MW    = 16,
    parameter int NW    = 8,
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       opcode,
    input logic             wide,
    input logic [RES_W-1:0] result,
    input logic             zf,
    input logic             cf,
    input logic             flag_valid
);

    logic tst;
    assign tst = op_valid && (opcode == 4'd10 || opcode == 4'd11);

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tst |=> ($stable(zf) && $stable(cf)));                               // R8
    AST_FV_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        tst |=> flag_valid);                                                  // R8
    AST_FV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tst |=> !flag_valid);                                                // R8
    AST_IDLE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));                                       // R9
    AST_TEST_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        tst |=> $stable(result));                                             // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide && opcode <= 4'd9) |=> (result[RES_W-1:NW] == '0)); // R2
    AST_ORTEST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 4'd11) |=> !(zf && cf));                       // R7

endmodule

bind kmask_alu kmask_alu_chk #(.MW(MW), .NW(NW), .RES_W(RES_W)) i_kmask_alu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .wide       (wide),
    .result     (result),
    .zf         (zf),
    .cf         (cf),
    .flag_valid (flag_valid)
);

// File: tb/test_kmask_alu.sv
module test_kmask_alu;

    localparam logic [3:0] O_ADD = 4'd0, O_AND = 4'd1, O_ANDN = 4'd2, O_OR = 4'd3,
                           O_XOR = 4'd4, O_XNOR = 4'd5, O_NOT = 4'd6, O_SHL = 4'd7,
                           O_SHR = 4'd8, O_MOV = 4'd9, O_TEST = 4'd10, O_ORT = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        wide = 1'b0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic [4:0]  shamt = '0;
    logic [63:0] result;
    logic        zf, cf, flag_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    kmask_alu i_kmask_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .wide(wide), .src_a(src_a), .src_b(src_b), .shamt(shamt),
        .result(result), .zf(zf), .cf(cf), .flag_valid(flag_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic apply(input logic [3:0] op, input logic w,
                         input logic [15:0] a, input logic [15:0] b, input logic [4:0] s);
        op_valid = 1'b1; opcode = op; wide = w; src_a = a; src_b = b; shamt = s;
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 result", result, 64'h0);
        chk("R1 zf", {63'h0, zf}, 64'h0);
        chk("R1 cf", {63'h0, cf}, 64'h0);
        chk("R1 flag_valid", {63'h0, flag_valid}, 64'h0);
    endtask

    task automatic t_add;
        apply(O_ADD, 1'b0, 16'h12F0, 16'hAB20, 5'd0);
        chk("R2 add8 wrap", result, 64'h10);
        apply(O_ADD, 1'b1, 16'hFFFF, 16'h0002, 5'd0);
        chk("R2 add16 wrap", result, 64'h1);
        apply(O_ADD, 1'b1, 16'h1234, 16'h0101, 5'd0);
        chk("R2 add16", result, 64'h1335);
    endtask

    task automatic t_logic;
        apply(O_AND, 1'b0, 16'hFF3C, 16'hFF0F, 5'd0);
        chk("R3 and8", result, 64'h0C);
        apply(O_ANDN, 1'b0, 16'h00F0, 16'hFFFF, 5'd0);
        chk("R3 andn8", result, 64'h0F);
        apply(O_ANDN, 1'b1, 16'h00F0, 16'hFFFF, 5'd0);
        chk("R3 andn16", result, 64'hFF0F);
        apply(O_OR, 1'b0, 16'h5501, 16'hAA10, 5'd0);
        chk("R3 or8", result, 64'h11);
        apply(O_XOR, 1'b1, 16'hF0F0, 16'hFF00, 5'd0);
        chk("R3 xor16", result, 64'h0FF0);
        apply(O_XNOR, 1'b0, 16'h00A5, 16'h00A4, 5'd0);
        chk("R3 xnor8", result, 64'hFE);
        apply(O_XNOR, 1'b1, 16'h00A5, 16'h00A4, 5'd0);
        chk("R3 xnor16", result, 64'hFFFE);
        apply(O_NOT, 1'b0, 16'h1234, 16'h0000, 5'd0);
        chk("R3 not8", result, 64'hCB);
    endtask

    task automatic t_shift;
        apply(O_SHL, 1'b0, 16'hFF81, 16'h0, 5'd3);
        chk("R4 shl8", result, 64'h08);
        apply(O_SHR, 1'b0, 16'hFF81, 16'h0, 5'd3);
        chk("R4 shr8 upper ignored", result, 64'h10);
        apply(O_SHR, 1'b1, 16'h8001, 16'h0, 5'd4);
        chk("R4 shr16", result, 64'h0800);
        apply(O_SHL, 1'b1, 16'h0001, 16'h0, 5'd15);
        chk("R4 shl16 by 15", result, 64'h8000);
        apply(O_SHL, 1'b0, 16'h00FF, 16'h0, 5'd8);
        chk("R4 shl8 by width", result, 64'h0);
        apply(O_SHR, 1'b1, 16'hFFFF, 16'h0, 5'd16);
        chk("R4 shr16 by width", result, 64'h0);
        apply(O_SHL, 1'b1, 16'hFFFF, 16'h0, 5'd31);
        chk("R4 shl16 by 31", result, 64'h0);
    endtask

    task automatic t_mov;
        apply(O_MOV, 1'b0, 16'hABCD, 16'h1111, 5'd0);
        chk("R5 mov8", result, 64'hCD);
        apply(O_MOV, 1'b1, 16'hABCD, 16'h1111, 5'd0);
        chk("R5 mov16", result, 64'hABCD);
    endtask

    task automatic t_test;
        apply(O_TEST, 1'b0, 16'h000F, 16'h00F0, 5'd0);
        chk("R6 test zf", {62'h0, zf, cf}, 64'h2);
        chk("R8 flag_valid after test", {63'h0, flag_valid}, 64'h1);
        @(posedge clk); @(negedge clk);
        chk("R8 flag_valid drops", {63'h0, flag_valid}, 64'h0);
        apply(O_TEST, 1'b0, 16'h00FF, 16'h000F, 5'd0);
        chk("R6 test cf", {62'h0, zf, cf}, 64'h1);
        apply(O_TEST, 1'b1, 16'h1234, 16'h0000, 5'd0);
        chk("R6 test empty b", {62'h0, zf, cf}, 64'h3);
        apply(O_TEST, 1'b0, 16'h0100, 16'h0300, 5'd0);
        chk("R6 test narrow ignores upper", {62'h0, zf, cf}, 64'h3);
        apply(O_TEST, 1'b1, 16'h0100, 16'h0300, 5'd0);
        chk("R6 test wide", {62'h0, zf, cf}, 64'h0);
    endtask

    task automatic t_ortest;
        apply(O_ORT, 1'b0, 16'hFFF0, 16'h000F, 5'd0);
        chk("R7 ortest all ones 8", {62'h0, zf, cf}, 64'h1);
        apply(O_ORT, 1'b0, 16'h0F00, 16'hF000, 5'd0);
        chk("R7 ortest zero 8", {62'h0, zf, cf}, 64'h2);
        apply(O_ORT, 1'b1, 16'h00FF, 16'h0F00, 5'd0);
        chk("R7 ortest partial 16", {62'h0, zf, cf}, 64'h0);
        apply(O_ORT, 1'b1, 16'hFF00, 16'h00FF, 5'd0);
        chk("R7 ortest all ones 16", {62'h0, zf, cf}, 64'h1);
    endtask

    task automatic t_hold;
        apply(O_MOV, 1'b1, 16'h5A5A, 16'h0, 5'd0);
        apply(O_TEST, 1'b1, 16'h00FF, 16'hFF00, 5'd0);
        chk("R9 test keeps result", result, 64'h5A5A);
        chk("R6 flags", {62'h0, zf, cf}, 64'h2);
        apply(O_ADD, 1'b1, 16'h0001, 16'h0001, 5'd0);
        chk("R8 add keeps flags", {62'h0, zf, cf}, 64'h2);
        chk("R8 no flag_valid on add", {63'h0, flag_valid}, 64'h0);
        chk("R2 add result", result, 64'h2);
        apply(4'd14, 1'b1, 16'hFFFF, 16'hFFFF, 5'd3);
        chk("R9 reserved keeps result", result, 64'h2);
        chk("R9 reserved keeps flags", {62'h0, zf, cf}, 64'h2);
        chk("R8 no flag_valid on reserved", {63'h0, flag_valid}, 64'h0);
        opcode = O_ADD; src_a = 16'h00FF; src_b = 16'h00FF;
        @(posedge clk); @(negedge clk);
        chk("R9 idle keeps result", result, 64'h2);
    endtask

    task automatic t_back_to_back;
        op_valid = 1'b1; opcode = O_ORT; wide = 1'b0; src_a = 16'h00FF; src_b = 16'h0;
        @(posedge clk); @(negedge clk);
        opcode = O_TEST; src_a = 16'h00FF; src_b = 16'h00FF;
        chk("R8 first of pair valid", {63'h0, flag_valid}, 64'h1);
        chk("R7 first of pair flags", {62'h0, zf, cf}, 64'h1);
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0;
        chk("R8 second of pair valid", {63'h0, flag_valid}, 64'h1);
        chk("R6 second of pair flags", {62'h0, zf, cf}, 64'h1);
        @(posedge clk); @(negedge clk);
        chk("R8 valid ends after pair", {63'h0, flag_valid}, 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_logic();
        t_shift();
        t_mov();
        t_test();
        t_ortest();
        t_hold();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule